// File: doc/BRIEF.md
# Two-Domain Video Frame Timer with Wait-for-Video Handshake

This block times video frames in a pixel clock domain while software programs it from a system clock domain. A scale word carries two fields: the frame length in pixel clocks (low 12 bits) and the clocks-per-pixel count (the field directly above it). The frame timer restarts its counters at every frame boundary. At that boundary it reloads both fields from the most recently committed scale word and takes over any pending pixel and colour data.

On the system side, a requester presents one frame of pixel and colour data with a one-cycle request. The block raises busy and holds the data until the pixel domain has latched it at a frame boundary. It then pulses an acknowledge. The scale word and the request cross into the pixel domain through toggle handshakes with multi-flop synchronizers. A multi-bit value is therefore never sampled while some of its bits are still changing. A frame length of 1 makes the timer reload on every pixel clock. This is the usual setting while the pixel clock settles, before a real frame length is written.

Top module: `vfs_frame_scaler`

## Requirements
- R1: With a frame-length field of N (1..4095) and the enable held high, `frame_start` pulses once every N pixel clocks.
- R2: A frame-length field of zero gives a frame of 4096 pixel clocks.
- R3: A frame-length field of 1 asserts `frame_start` on every enabled pixel clock.
- R4: The clocks-per-pixel field sits at bits [12 +: CPP_W] of `scale_wdata`, and a zero there means 2^CPP_W. `pixel_strobe` is high on the first clock of each frame and on every C-th enabled clock after it, so a frame of N clocks holds ceil(N/C) strobes.
- R5: A scale write takes effect at the first frame boundary after it has crossed into the pixel domain. A frame already running keeps its length. Of back-to-back writes, the last one wins.
- R6: `vid_req` while `vid_busy` is low takes `vid_pix_in`/`vid_col_in`. `vid_busy` is high from the next cycle until the single-cycle `vid_ack` pulse, and `vid_busy` is low again in the cycle that pulse is seen. When the pulse is seen, `vid_pix_out`/`vid_col_out` already hold the sent data.
- R7: `vid_pix_out`/`vid_col_out` change only at a frame boundary with a request pending. Without a request pending they keep their value across frames.
- R8: While `pix_en` is low, `frame_start` and `pixel_strobe` stay low, the counters hold, and no reload or acknowledge occurs. When `pix_en` returns high, counting resumes, so a frame still spans exactly N enabled clocks.
- R9: After reset `vid_busy`, `vid_ack` and the data outputs are zero, the scale word is zero (4096-clock frames, 2^CPP_W clocks per pixel), and the first enabled pixel clock starts a frame.
- R10: A `vid_req` that arrives while `vid_busy` is high is ignored. The data in flight is neither replaced nor delivered twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | System-domain asynchronous reset, active low |
| scale_we | input | 1 | Scale word write strobe |
| scale_wdata | input | LEN_W+CPP_W | Scale word: clocks per pixel above frame length |
| vid_req | input | 1 | Wait-for-video request, one cycle |
| vid_pix_in | input | PIX_W | Pixel data for one frame |
| vid_col_in | input | COL_W | Colour data for one frame |
| vid_busy | output | 1 | Request in flight |
| vid_ack | output | 1 | Single-cycle pulse: data taken by the pixel domain |
| pix_clk | input | 1 | Pixel clock |
| pix_rst_n | input | 1 | Pixel-domain asynchronous reset, active low |
| pix_en | input | 1 | Generator enable; low freezes counters |
| vid_pix_out | output | PIX_W | Pixel data of the current frame |
| vid_col_out | output | COL_W | Colour data of the current frame |
| frame_start | output | 1 | High on the first enabled clock of each frame |
| pixel_strobe | output | 1 | High on the first enabled clock of each pixel |

## Verification
The bench targets the zero-means-maximum decode on both fields. A design that treats zero literally would produce a one-clock or runaway frame, and the wrong strobe count. It rewrites the scale word in the middle of a frame. A design that reloads early would cut that frame short, and one that captures the word mid-change would use a length nobody wrote. It sends a second request while the first is still in flight, which a careless design would let overwrite the held data. It drops the enable in the middle of a frame and during a pending request. A design that keeps counting or reloads while disabled shows a short frame or an acknowledge that should not have come.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
   // Depth of the synchronizer chains used for every crossing in the block.
   typedef enum logic [0:0] {
      VFS_SYNC_2FF = 1'b0,
      VFS_SYNC_3FF = 1'b1
   } vfs_sync_e;

   localparam int unsigned VFS_LEN_W_DEF = 12;
   localparam int unsigned VFS_CPP_W_DEF = 8;

   function automatic int unsigned vfs_stages(input vfs_sync_e sel);
      return (sel == VFS_SYNC_3FF) ? 3 : 2;
   endfunction
endpackage

// File: rtl/vfs_sync_bit.sv
module vfs_sync_bit #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("vfs_sync_bit: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/vfs_scale_xfer.sv
// Carries the scale word from the system domain to the pixel domain.
// A write lands in a pending slot; only when no transfer is in flight is it
// moved to a frozen holding register and announced by a request toggle.
module vfs_scale_xfer #(
   parameter int           W       = 20,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         s_clk,
   input  logic         s_rst_n,
   input  logic         s_we,
   input  logic [W-1:0] s_wdata,
   input  logic         d_clk,
   input  logic         d_rst_n,
   output logic [W-1:0] d_scale
);
   logic [W-1:0] pend_q, hold_q;
   logic         pend_v_q, inflight_q, req_t_q, ack_seen_q;
   logic         ack_s, ack_edge, launch;
   logic         req_s, req_seen_q;

   vfs_sync_bit #(.STAGES(STAGES)) u_ack_sync (
      .clk(s_clk), .rst_n(s_rst_n), .d(req_seen_q), .q(ack_s));

   assign ack_edge = ack_s ^ ack_seen_q;
   assign launch   = pend_v_q & ~inflight_q;

   always_ff @(posedge s_clk or negedge s_rst_n) begin
      if (!s_rst_n) begin
         pend_q     <= RST_VAL;
         hold_q     <= RST_VAL;
         pend_v_q   <= 1'b0;
         inflight_q <= 1'b0;
         req_t_q    <= 1'b0;
         ack_seen_q <= 1'b0;
      end else begin
         if (s_we) pend_q <= s_wdata;
         pend_v_q <= s_we | (pend_v_q & ~launch);
         if (launch) begin
            hold_q  <= pend_q;
            req_t_q <= ~req_t_q;
         end
         if (launch)        inflight_q <= 1'b1;
         else if (ack_edge) inflight_q <= 1'b0;
         if (ack_edge) ack_seen_q <= ack_s;
      end
   end

   vfs_sync_bit #(.STAGES(STAGES)) u_req_sync (
      .clk(d_clk), .rst_n(d_rst_n), .d(req_t_q), .q(req_s));

   always_ff @(posedge d_clk or negedge d_rst_n) begin
      if (!d_rst_n) begin
         d_scale    <= RST_VAL;
         req_seen_q <= 1'b0;
      end else if (req_s != req_seen_q) begin
         d_scale    <= hold_q;
         req_seen_q <= req_s;
      end
   end

   // R5: the word seen by the pixel side never moves while it may be sampled
   p_hold_frozen_r5: assert property (@(posedge s_clk) disable iff (!s_rst_n)
      inflight_q |=> $stable(hold_q));
   // R5: a transfer stays open until the pixel side has answered
   p_wait_answer_r5: assert property (@(posedge s_clk) disable iff (!s_rst_n)
      (inflight_q && !ack_edge) |=> inflight_q);
endmodule

// File: rtl/vfs_vid_xfer.sv
// Wait-for-video handshake: system side holds one frame of data under busy,
// pixel side takes it at a frame boundary and answers with a toggle.
module vfs_vid_xfer #(
   parameter int PW     = 32,
   parameter int CW     = 32,
   parameter int STAGES = 2
) (
   input  logic          s_clk,
   input  logic          s_rst_n,
   input  logic          s_req,
   input  logic [PW-1:0] s_pix,
   input  logic [CW-1:0] s_col,
   output logic          s_busy,
   output logic          s_ack,
   input  logic          d_clk,
   input  logic          d_rst_n,
   input  logic          d_take,
   output logic [PW-1:0] d_pix,
   output logic [CW-1:0] d_col
);
   logic [PW-1:0] hold_pix_q;
   logic [CW-1:0] hold_col_q;
   logic          req_t_q, done_seen_q, busy_q, ack_q;
   logic          done_s, done_edge, accept;
   logic          req_s, seen_q, pending;

   vfs_sync_bit #(.STAGES(STAGES)) u_done_sync (
      .clk(s_clk), .rst_n(s_rst_n), .d(seen_q), .q(done_s));

   assign done_edge = done_s ^ done_seen_q;
   assign accept    = s_req & ~busy_q;

   always_ff @(posedge s_clk or negedge s_rst_n) begin
      if (!s_rst_n) begin
         hold_pix_q  <= '0;
         hold_col_q  <= '0;
         req_t_q     <= 1'b0;
         done_seen_q <= 1'b0;
         busy_q      <= 1'b0;
         ack_q       <= 1'b0;
      end else begin
         ack_q <= done_edge;
         if (accept) begin
            hold_pix_q <= s_pix;
            hold_col_q <= s_col;
            req_t_q    <= ~req_t_q;
            busy_q     <= 1'b1;
         end else if (done_edge) begin
            busy_q <= 1'b0;
         end
         if (done_edge) done_seen_q <= done_s;
      end
   end

   assign s_busy = busy_q;
   assign s_ack  = ack_q;

   vfs_sync_bit #(.STAGES(STAGES)) u_req_sync (
      .clk(d_clk), .rst_n(d_rst_n), .d(req_t_q), .q(req_s));

   assign pending = req_s ^ seen_q;

   always_ff @(posedge d_clk or negedge d_rst_n) begin
      if (!d_rst_n) begin
         d_pix  <= '0;
         d_col  <= '0;
         seen_q <= 1'b0;
      end else if (d_take && pending) begin
         d_pix  <= hold_pix_q;
         d_col  <= hold_col_q;
         seen_q <= req_s;
      end
   end

   // R6: acknowledge is a single-cycle pulse
   p_ack_pulse_r6: assert property (@(posedge s_clk) disable iff (!s_rst_n)
      s_ack |=> !s_ack);
   // R6: busy only drops together with the acknowledge
   p_busy_release_r6: assert property (@(posedge s_clk) disable iff (!s_rst_n)
      $fell(busy_q) |-> ack_q);
   // R10: data in flight cannot be replaced by a later request
   p_hold_frozen_r10: assert property (@(posedge s_clk) disable iff (!s_rst_n)
      busy_q |=> ($stable(hold_pix_q) && $stable(hold_col_q)));
   // R7: outputs only move on a frame boundary
   p_take_only_r7: assert property (@(posedge d_clk) disable iff (!d_rst_n)
      !d_take |=> ($stable(d_pix) && $stable(d_col)));
endmodule

// File: rtl/vfs_frame_core.sv
// Pixel-domain frame and pixel counters with reload at the frame boundary.
module vfs_frame_core #(
   parameter int LEN_W = 12,
   parameter int CPP_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic [LEN_W+CPP_W-1:0] scale,
   output logic                   take,
   output logic                   frame_start,
   output logic                   pixel_strobe
);
   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
   localparam logic [CPP_W-1:0] CPP_ONE = CPP_W'(1);

   generate
      if (LEN_W < 1 || CPP_W < 1) begin : g_bad
         $error("vfs_frame_core: field widths must be at least 1");
      end
   endgenerate

   // Both limits are stored minus one, so a zero field wraps to the maximum.
   logic [LEN_W-1:0] fcnt_q, len_m1_q, new_len_m1;
   logic [CPP_W-1:0] pcnt_q, cpp_m1_q, new_cpp_m1;
   logic             last_clk;

   assign new_len_m1 = scale[LEN_W-1:0] - LEN_ONE;
   assign new_cpp_m1 = scale[LEN_W +: CPP_W] - CPP_ONE;
   assign last_clk   = (fcnt_q == len_m1_q);
   assign take       = en & last_clk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt_q   <= '0;
         pcnt_q   <= '0;
         len_m1_q <= '1;
         cpp_m1_q <= '1;
      end else if (en) begin
         if (last_clk) begin
            fcnt_q   <= '0;
            pcnt_q   <= '0;
            len_m1_q <= new_len_m1;
            cpp_m1_q <= new_cpp_m1;
         end else begin
            fcnt_q <= fcnt_q + LEN_ONE;
            pcnt_q <= (pcnt_q == cpp_m1_q) ? '0 : pcnt_q + CPP_ONE;
         end
      end
   end

   assign frame_start  = en & (fcnt_q == '0);
   assign pixel_strobe = en & (pcnt_q == '0);

   // R1: the frame position never passes the active frame length
   p_fcnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fcnt_q <= len_m1_q);
   // R1: a reload restarts both counters
   p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (fcnt_q == '0 && pcnt_q == '0));
   // R4: the pixel position stays inside the active pixel width
   p_pcnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt_q <= cpp_m1_q);
   // R8: disabled generator freezes everything
   p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(fcnt_q) && $stable(pcnt_q) && $stable(len_m1_q)));
endmodule

// File: rtl/vfs_frame_scaler.sv
module vfs_frame_scaler
   import vfs_pkg::*;
#(
   parameter int        LEN_W      = VFS_LEN_W_DEF,
   parameter int        CPP_W      = VFS_CPP_W_DEF,
   parameter int        PIX_W      = 32,
   parameter int        COL_W      = 32,
   parameter vfs_sync_e SYNC_DEPTH = VFS_SYNC_2FF
) (
   input  logic                   sys_clk,
   input  logic                   sys_rst_n,
   input  logic                   scale_we,
   input  logic [LEN_W+CPP_W-1:0] scale_wdata,
   input  logic                   vid_req,
   input  logic [PIX_W-1:0]       vid_pix_in,
   input  logic [COL_W-1:0]       vid_col_in,
   output logic                   vid_busy,
   output logic                   vid_ack,
   input  logic                   pix_clk,
   input  logic                   pix_rst_n,
   input  logic                   pix_en,
   output logic [PIX_W-1:0]       vid_pix_out,
   output logic [COL_W-1:0]       vid_col_out,
   output logic                   frame_start,
   output logic                   pixel_strobe
);
   localparam int SCALE_W = LEN_W + CPP_W;
   localparam int STAGES  = vfs_stages(SYNC_DEPTH);

   logic [SCALE_W-1:0] pix_scale;
   logic               take;

   vfs_scale_xfer #(.W(SCALE_W), .STAGES(STAGES), .RST_VAL('0)) u_scale (
      .s_clk(sys_clk), .s_rst_n(sys_rst_n), .s_we(scale_we), .s_wdata(scale_wdata),
      .d_clk(pix_clk), .d_rst_n(pix_rst_n), .d_scale(pix_scale));

   vfs_frame_core #(.LEN_W(LEN_W), .CPP_W(CPP_W)) u_core (
      .clk(pix_clk), .rst_n(pix_rst_n), .en(pix_en), .scale(pix_scale),
      .take(take), .frame_start(frame_start), .pixel_strobe(pixel_strobe));

   vfs_vid_xfer #(.PW(PIX_W), .CW(COL_W), .STAGES(STAGES)) u_vid (
      .s_clk(sys_clk), .s_rst_n(sys_rst_n), .s_req(vid_req),
      .s_pix(vid_pix_in), .s_col(vid_col_in), .s_busy(vid_busy), .s_ack(vid_ack),
      .d_clk(pix_clk), .d_rst_n(pix_rst_n), .d_take(take),
      .d_pix(vid_pix_out), .d_col(vid_col_out));

   // R8: no reload, hence no data hand-over, while the generator is off
   p_no_take_disabled_r8: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
      !pix_en |-> !take);
endmodule

// File: tb/vfs_frame_scaler_test.sv
`timescale 1ns/1ps
module vfs_frame_scaler_test;
   localparam int LEN_W = 12;
   localparam int CPP_W = 8;
   localparam int PIX_W = 32;
   localparam int COL_W = 32;

   logic sys_clk = 1'b0, pix_clk = 1'b0;
   logic sys_rst_n = 1'b0, pix_rst_n = 1'b0;
   logic scale_we = 1'b0;
   logic [LEN_W+CPP_W-1:0] scale_wdata = '0;
   logic vid_req = 1'b0;
   logic [PIX_W-1:0] vid_pix_in = '0;
   logic [COL_W-1:0] vid_col_in = '0;
   logic vid_busy, vid_ack;
   logic pix_en = 1'b0;
   logic [PIX_W-1:0] vid_pix_out;
   logic [COL_W-1:0] vid_col_out;
   logic frame_start, pixel_strobe;

   int compared = 0, mismatched = 0;
   int fn, fs, gap_bad;

   always #4.0 sys_clk = ~sys_clk;   // 125 MHz
   always #3.5 pix_clk = ~pix_clk;   // unrelated pixel clock

   vfs_frame_scaler #(.LEN_W(LEN_W), .CPP_W(CPP_W), .PIX_W(PIX_W), .COL_W(COL_W)) uut (
      .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .scale_we(scale_we), .scale_wdata(scale_wdata),
      .vid_req(vid_req), .vid_pix_in(vid_pix_in), .vid_col_in(vid_col_in),
      .vid_busy(vid_busy), .vid_ack(vid_ack), .pix_clk(pix_clk), .pix_rst_n(pix_rst_n),
      .pix_en(pix_en), .vid_pix_out(vid_pix_out), .vid_col_out(vid_col_out),
      .frame_start(frame_start), .pixel_strobe(pixel_strobe));

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic int full_len(input int f);
      return (f == 0) ? 4096 : f;
   endfunction

   function automatic int strobes(input int len, input int cppf);
      int c = (cppf == 0) ? 256 : cppf;
      return (len + c - 1) / c;
   endfunction

   task automatic pstep(); @(negedge pix_clk); #1; endtask
   task automatic sstep(); @(negedge sys_clk); #1; endtask

   task automatic wr_scale(input int len, input int cpp);
      sstep();
      scale_we    = 1'b1;
      scale_wdata = {CPP_W'(cpp), LEN_W'(len)};
      sstep();
      scale_we = 1'b0;
   endtask

   task automatic settle(); repeat (30) pstep(); endtask

   task automatic wait_start();
      do pstep(); while (!frame_start);
   endtask

   // Called with frame_start high; counts enabled clocks and strobes up to the next start.
   task automatic count_frame(input int gap_at, input int gap_len, output int n, output int s);
      n = 0; s = 0; gap_bad = 0;
      do begin
         if (pixel_strobe) s++;
         n++;
         pstep();
         if (n == gap_at && gap_len > 0) begin
            pix_en = 1'b0; #1;
            for (int k = 0; k < gap_len; k++) begin
               if (frame_start || pixel_strobe) gap_bad++;
               pstep();
            end
            pix_en = 1'b1; #1;
         end
      end while (!frame_start);
   endtask

   task automatic measure(input int lenf, input int cppf, input string rq);
      wait_start();
      count_frame(-1, 0, fn, fs);
      chk(fn == full_len(lenf), {rq, " frame length"}, fn, full_len(lenf));
      chk(fs == strobes(full_len(lenf), cppf), "R4 strobe count", fs, strobes(full_len(lenf), cppf));
   endtask

   task automatic vid_fire(input logic [PIX_W-1:0] p, input logic [COL_W-1:0] c);
      sstep();
      vid_req = 1'b1; vid_pix_in = p; vid_col_in = c;
      sstep();
      vid_req = 1'b0;
   endtask

   task automatic vid_wait_ack(output bit got);
      got = 1'b0;
      for (int k = 0; k < 3000 && !got; k++) begin
         if (vid_ack) got = 1'b1;
         else sstep();
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      #1_200_000;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      bit got;
      logic [PIX_W-1:0] pa, pb;
      logic [COL_W-1:0] ca, cb;
      void'($urandom(32'h5EED_0042));

      repeat (5) sstep();
      sys_rst_n = 1'b1;
      pstep();
      pix_rst_n = 1'b1;
      repeat (3) pstep();

      // R9 reset state; R8 nothing while disabled
      chk(vid_busy == 1'b0, "R9 busy after reset", vid_busy, 0);
      chk(vid_ack == 1'b0, "R9 ack after reset", vid_ack, 0);
      chk(vid_pix_out == '0 && vid_col_out == '0, "R9 data after reset", vid_pix_out, 0);
      chk(!frame_start && !pixel_strobe, "R8 quiet while disabled", frame_start, 0);
      pix_en = 1'b1; #1;
      chk(frame_start == 1'b1, "R9 first enabled clock starts frame", frame_start, 1);
      count_frame(-1, 0, fn, fs);
      chk(fn == 4096, "R2 reset frame length", fn, 4096);
      chk(fs == 16, "R4 reset cpp zero strobes", fs, 16);

      // R3: length 1 reloads every pixel clock
      wr_scale(1, 1); settle();
      wait_start();
      for (int k = 0; k < 6; k++) begin
         chk(frame_start && pixel_strobe, "R3 start every clock", frame_start, 1);
         pstep();
      end

      // R4: zero clocks-per-pixel field
      wr_scale(300, 0); settle();
      measure(300, 0, "R1");
      // R2: zero frame-length field with a non-zero pixel width
      wr_scale(0, 3); settle();
      measure(0, 3, "R2");

      // R5: write in the middle of a frame does not cut it
      wr_scale(200, 1); settle();
      wait_start();
      fork
         count_frame(-1, 0, fn, fs);
         wr_scale(50, 1);
      join
      chk(fn == 200, "R5 running frame keeps length", fn, 200);
      count_frame(-1, 0, fn, fs);
      chk(fn == 50, "R5 next frame takes new length", fn, 50);

      // R5: last write wins
      wr_scale(30, 2);
      wr_scale(70, 4);
      settle();
      measure(70, 4, "R5");

      // R1/R4/R8: random configurations, some with an enable gap
      for (int it = 0; it < 10; it++) begin
         int len = $urandom_range(300, 1);
         int cpp = $urandom_range(9, 1);
         wr_scale(len, cpp); settle();
         wait_start();
         if (it % 2 == 1 && len > 2) begin
            int gat = $urandom_range(len - 1, 1);
            int glen = $urandom_range(20, 1);
            count_frame(gat, glen, fn, fs);
            chk(fn == len, "R8 frame spans enabled clocks", fn, len);
            chk(gap_bad == 0, "R8 no strobes while disabled", gap_bad, 0);
         end else begin
            count_frame(-1, 0, fn, fs);
            chk(fn == len, "R1 frame length", fn, len);
         end
         chk(fs == strobes(len, cpp), "R4 strobe count", fs, strobes(len, cpp));
      end

      // R6: basic wait-for-video handshake
      wr_scale(40, 1); settle();
      for (int it = 0; it < 3; it++) begin
         pa = $urandom(); ca = $urandom();
         vid_fire(pa, ca);
         chk(vid_busy == 1'b1, "R6 busy after request", vid_busy, 1);
         vid_wait_ack(got);
         chk(got, "R6 ack arrives", got, 1);
         chk(vid_busy == 1'b0, "R6 busy clear with ack", vid_busy, 0);
         chk(vid_pix_out == pa && vid_col_out == ca, "R6 data delivered", vid_pix_out, pa);
         sstep();
         chk(vid_ack == 1'b0, "R6 ack single cycle", vid_ack, 0);
      end

      // R10: second request during busy is ignored
      wr_scale(400, 1); settle();
      pa = $urandom(); ca = $urandom(); pb = ~pa; cb = ~ca;
      vid_fire(pa, ca);
      vid_fire(pb, cb);
      vid_wait_ack(got);
      chk(got, "R10 first ack arrives", got, 1);
      chk(vid_pix_out == pa && vid_col_out == ca, "R10 first data kept", vid_pix_out, pa);
      // R7: no request pending, outputs stay across frames
      wait_start(); wait_start(); pstep();
      chk(vid_pix_out == pa && vid_col_out == ca, "R7 data stable without request", vid_pix_out, pa);
      chk(vid_busy == 1'b0, "R10 no second transfer", vid_busy, 0);

      // R8: no ack while disabled
      wr_scale(20, 1); settle();
      pstep(); pix_en = 1'b0;
      pa = $urandom(); ca = $urandom();
      vid_fire(pa, ca);
      got = 1'b0;
      for (int k = 0; k < 100; k++) begin
         if (vid_ack) got = 1'b1;
         sstep();
      end
      chk(!got, "R8 no ack while disabled", got, 0);
      chk(vid_busy == 1'b1, "R8 request still pending", vid_busy, 1);
      pstep(); pix_en = 1'b1;
      vid_wait_ack(got);
      chk(got, "R8 ack after re-enable", got, 1);
      chk(vid_pix_out == pa, "R8 data after re-enable", vid_pix_out, pa);

      summary();
      $finish;
   end
endmodule